// File: doc/BRIEF.md
# Audio Playback DMA Sequencer

This block plays a stream of audio samples out of memory onto a serial DAC bus. Software queues transfers as (start address, byte length) pairs. Up to two pairs can be held at once: the one being played and one waiting behind it. The engine reads 64-bit words from memory over a fixed-latency request/response port. Each word carries two 32-bit sample frames, and the upper frame is sent first. The frames are shifted out MSB first, together with a bit clock and a word-select line.

Two divisors of the single reference clock set the DAC timing. One sets the frame period and the other sets the bit-clock half-period. When the transfer being played runs out, the waiting one takes its place at once. When nothing more is queued, the last frame repeats. An interrupt is raised each time the queue leaves the full state. This tells software that a slot has opened.

Register map (3-bit index): 0 start address (write), 1 length (write commits, read gives remaining bytes), 2 control (write), 3 status (read; any write clears the interrupt), 4 frame divisor (write), 5 bit-clock divisor (write).

Top module: `audio_dma_seq`

## Requirements
- R1: A write to index 1 commits a descriptor. The descriptor takes the most recently written address, using bits 23:3 with bits 2:0 forced to zero, and the length from write data bits 20:3 with bits 2:0 forced to zero. A length whose bits 20:3 are all zero is discarded.
- R2: The queue holds at most two descriptors, and a commit made while it holds two is ignored. The status word at index 3 has full (two held) at bit 31 and again at bit 0, busy (at least one held) at bit 27, and the word-select level at bit 21. All other status bits are 0.
- R3: Reading index 1 returns the bytes not yet fetched of the active transfer, or 0 when the queue is empty.
- R4: Bit 0 of the control word enables fetching. While it is 0, no memory request is issued, and a pending descriptor keeps its length.
- R5: The block fetches one 64-bit word for each 8 bytes, at ascending addresses, with at most one request outstanding. After the last word of a transfer, the next request uses the queued descriptor.
- R6: The interrupt goes high one cycle after the full flag falls from 1 to 0. Any write to index 3 clears it, and a new rise wins over a clear in the same cycle. Going from one descriptor to none does not raise it.
- R7: With a bit-clock divisor h other than 0, the bit clock toggles every h+1 cycles. With h equal to 0, the bit clock is held low.
- R8: With frame divisor d, a new frame starts every d+1 cycles. At each frame start a new 32-bit sample is loaded, taking the upper half of each memory word before the lower half. Word select is high from the frame start until the 16th falling edge of the bit clock. Data leaves MSB first and advances on each falling edge of the bit clock.
- R9: If no fetched sample is waiting at a frame start, the previous frame's sample is sent again. After reset this sample is 0.
- R10: After reset the interrupt, memory request, bit clock and data output are low. Reads of indices other than 1 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 24 | Byte address of requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data word |
| dac_bclk | output | 1 | Serial bit clock |
| dac_ws | output | 1 | Word select |
| dac_data | output | 1 | Serial sample data |
| irq | output | 1 | Slot-free interrupt |

## Verification
A register write takes effect on the next rising edge, and register reads are combinational, so status and length are read at the falling edge that follows each write. The interrupt is due one edge after the full flag drops, and a memory request appears in the same cycle in which its conditions become true. The bench therefore polls both at every falling edge, with a bounded wait. Frame contents are rebuilt from the serial pins. The bench restarts at each rise of word select and takes the data bit present just before each bit-clock fall, skipping a fall that coincides with the frame load, as the block does. The bit-clock half-period and the frame period are measured in whole reference cycles between output edges.

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 21,
  parameter int MEM_W  = 64,
  parameter int RATE_W = 14,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [MEM_W-1:0]  mem_rdata,
  output logic              dac_bclk,
  output logic              dac_ws,
  output logic              dac_data,
  output logic              irq
);
  localparam int SMP_W     = MEM_W / 2;
  localparam int STEP      = MEM_W / 8;
  localparam int AL        = $clog2(STEP);
  localparam int HALF_BITS = SMP_W / 2;
  localparam int IDX_W     = $clog2(SMP_W) + 1;

  logic [ADDR_W-1:0] addr_hold, a0, a1;
  logic [LEN_W-1:0]  l0, l1;
  logic [1:0]        cnt;
  logic              en, pend, wv, half, full_q, irq_q, bclk_q;
  logic [MEM_W-1:0]  wbuf;
  logic [SMP_W-1:0]  sh, last;
  logic [RATE_W-1:0] dper, div;
  logic [HALF_W-1:0] hp, bc;
  logic [IDX_W-1:0]  idx;
  logic              unused_bits;

  wire wr_addr = reg_wr && reg_addr == 3'd0;
  wire wr_len  = reg_wr && reg_addr == 3'd1;
  wire wr_ctl  = reg_wr && reg_addr == 3'd2;
  wire wr_stat = reg_wr && reg_addr == 3'd3;
  wire wr_dper = reg_wr && reg_addr == 3'd4;
  wire wr_hp   = reg_wr && reg_addr == 3'd5;

  wire [LEN_W-1:0] len_in = {reg_wdata[LEN_W-1:AL], {AL{1'b0}}};
  wire full   = cnt == 2'd2;
  wire busy   = cnt != 2'd0;
  wire push   = wr_len && !full && len_in != '0;
  wire issue  = en && busy && !pend && !wv;
  wire pop    = issue && l0 == LEN_W'(STEP);
  wire [1:0] slot = cnt - {1'b0, pop};
  wire strobe = div >= dper;
  wire fall   = hp != '0 && bc >= hp && bclk_q;
  wire [SMP_W-1:0] next_smp = wv ? (half ? wbuf[SMP_W-1:0] : wbuf[MEM_W-1:SMP_W]) : last;

  assign unused_bits = ^reg_wdata[31:ADDR_W];
  assign mem_req  = issue;
  assign mem_addr = a0;
  assign dac_bclk = bclk_q;
  assign dac_ws   = idx < IDX_W'(HALF_BITS);
  assign dac_data = sh[SMP_W-1];
  assign irq      = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 3'd1) begin
      reg_rdata[LEN_W-1:0] = busy ? l0 : '0;
    end else if (reg_addr == 3'd3) begin
      reg_rdata[31] = full;
      reg_rdata[27] = busy;
      reg_rdata[21] = dac_ws;
      reg_rdata[0]  = full;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_hold <= '0; a0 <= '0; a1 <= '0; l0 <= '0; l1 <= '0; cnt <= '0;
    end else begin
      if (wr_addr) addr_hold <= {reg_wdata[ADDR_W-1:AL], {AL{1'b0}}};
      if (issue) begin
        if (pop) begin
          a0 <= a1; l0 <= l1;
        end else begin
          a0 <= a0 + ADDR_W'(STEP); l0 <= l0 - LEN_W'(STEP);
        end
      end
      if (push) begin
        if (slot == 2'd0) begin
          a0 <= addr_hold; l0 <= len_in;
        end else begin
          a1 <= addr_hold; l1 <= len_in;
        end
      end
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; pend <= 1'b0; wv <= 1'b0; half <= 1'b0; wbuf <= '0; last <= '0;
      dper <= '0; hp <= '0; full_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (wr_ctl)  en   <= reg_wdata[0];
      if (wr_dper) dper <= reg_wdata[RATE_W-1:0];
      if (wr_hp)   hp   <= reg_wdata[HALF_W-1:0];
      if (issue) pend <= 1'b1;
      else if (mem_rvalid) pend <= 1'b0;
      if (mem_rvalid) begin
        wbuf <= mem_rdata; wv <= 1'b1; half <= 1'b0;
      end else if (strobe && wv) begin
        if (half) wv <= 1'b0;
        half <= ~half;
      end
      if (strobe) last <= next_smp;
      full_q <= full;
      if (full_q && !full) irq_q <= 1'b1;
      else if (wr_stat) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0; bc <= '0; bclk_q <= 1'b0; sh <= '0; idx <= IDX_W'(SMP_W);
    end else begin
      div <= strobe ? '0 : div + 1'b1;
      if (hp == '0) begin
        bc <= '0; bclk_q <= 1'b0;
      end else if (bc >= hp) begin
        bc <= '0; bclk_q <= ~bclk_q;
      end else begin
        bc <= bc + 1'b1;
      end
      if (strobe) begin
        sh <= next_smp; idx <= '0;
      end else if (fall) begin
        sh <= {sh[SMP_W-2:0], 1'b0};
        if (idx != IDX_W'(SMP_W)) idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_dma_seq_chk.sv
module audio_dma_seq_chk #(
  parameter int HALF_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              mem_req,
  input logic              dac_bclk,
  input logic              irq,
  input logic [1:0]        cnt,
  input logic [HALF_W-1:0] hp
);
  p_depth_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  p_len_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd0 && reg_addr == 3'd1) |-> reg_rdata == 32'd0);

  p_disabled_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && !reg_wdata[0]) |=> !mem_req);

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_irq_on_slot_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt == 2'd2) |=> irq);

  p_bclk_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hp == '0) |=> !dac_bclk);
endmodule

bind audio_dma_seq audio_dma_seq_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
  .dac_bclk(dac_bclk), .irq(irq), .cnt(cnt), .hp(hp)
);

// File: tb/audio_dma_seq_test.sv
module audio_dma_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        dac_bclk, dac_ws, dac_data, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_dma_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dac_bclk(dac_bclk), .dac_ws(dac_ws), .dac_data(dac_data), .irq(irq)
  );

  // memory model: fixed latency, word = {A5,addr,5A,addr}
  logic        mv [3];
  logic [23:0] ma [3];
  logic [23:0] reqlog [16];
  int reqn = 0;
  always @(negedge clk) begin
    mv[2] = mv[1]; ma[2] = ma[1];
    mv[1] = mv[0]; ma[1] = ma[0];
    mv[0] = rst_n && mem_req; ma[0] = mem_addr;
    if (rst_n && mem_req) begin
      if (reqn < 16) reqlog[reqn] = mem_addr;
      reqn++;
    end
    mem_rvalid = mv[2];
    mem_rdata  = {8'hA5, ma[2], 8'h5A, ma[2]};
  end

  // frame capture from the serial pins
  bit cap_on = 0;
  logic [31:0] frames [32];
  logic [31:0] word;
  int fn = 0;
  int bits = 32;
  logic pws, pb, pd;
  always @(negedge clk) begin
    if (!cap_on) begin
      fn = 0; bits = 32;
    end else if (dac_ws && !pws) begin
      bits = 0; word = '0;
    end else if (!dac_bclk && pb && bits < 32) begin
      word = {word[30:0], pd};
      bits++;
      if (bits == 32 && fn < 32) begin
        frames[fn] = word;
        fn++;
      end
    end
    pws = dac_ws; pb = dac_bclk; pd = dac_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // {req, wr, addr, data, expected}
  localparam logic [71:0] VEC [16] = '{
    {4'd3,  1'b0, 3'd1, 32'h0,    32'h0},         // R3 idle length
    {4'd10, 1'b0, 3'd3, 32'h0,    32'h0020_0000}, // R10 status after reset
    {4'd10, 1'b0, 3'd5, 32'h0,    32'h0},         // R10 unread index
    {4'd1,  1'b1, 3'd0, 32'h100,  32'h0},
    {4'd1,  1'b1, 3'd1, 32'h0,    32'h0},         // R1 zero length dropped
    {4'd1,  1'b0, 3'd3, 32'h0,    32'h0020_0000},
    {4'd1,  1'b1, 3'd1, 32'h10,   32'h0},
    {4'd2,  1'b0, 3'd3, 32'h0,    32'h0820_0000}, // R2 busy
    {4'd3,  1'b0, 3'd1, 32'h0,    32'h10},        // R3 remaining
    {4'd1,  1'b1, 3'd0, 32'h200,  32'h0},
    {4'd1,  1'b1, 3'd1, 32'h1F,   32'h0},
    {4'd2,  1'b0, 3'd3, 32'h0,    32'h8820_0001}, // R2 full
    {4'd2,  1'b1, 3'd0, 32'h300,  32'h0},
    {4'd2,  1'b1, 3'd1, 32'h40,   32'h0},         // R2 commit while full
    {4'd2,  1'b0, 3'd1, 32'h0,    32'h10},
    {4'd2,  1'b0, 3'd3, 32'h0,    32'h8820_0001}
  };

  initial begin
    logic [31:0] d;
    logic [23:0] exp_addr [5];
    logic [31:0] exp_frm [8];
    int base, t, n, k;
    bit seen;
    logic p;
    exp_addr = '{24'h100, 24'h108, 24'h200, 24'h208, 24'h210};
    exp_frm = '{32'hA500_0400, 32'h5A00_0400, 32'hA500_0408, 32'h5A00_0408,
                32'hA500_0800, 32'h5A00_0800, 32'h5A00_0800, 32'h5A00_0800};
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {28'd0, irq, mem_req, dac_bclk, dac_data}, 32'd0, "reset outputs");
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dac_bclk) seen = 1;
    end
    chk("R7", {31'd0, seen}, 32'd0, "bit clock parked with zero divisor");

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][67]) begin
        wr(VEC[i][66:64], VEC[i][63:32]);
      end else begin
        rd(VEC[i][66:64], d);
        chk($sformatf("R%0d", VEC[i][71:68]), d, VEC[i][31:0], $sformatf("vector %0d", i));
        @(negedge clk);
      end
    end
    chk("R6", {31'd0, irq}, 32'd0, "no interrupt while queue fills");

    // drain: R5 fetch order, R6 interrupt
    base = reqn;
    wr(3'd2, 32'h1);
    t = 0;
    while (!irq && t < 200) begin @(negedge clk); t++; end
    chk("R6", {31'd0, irq}, 32'd1, "interrupt on full falling");
    rd(3'd3, d);
    chk("R2", d & 32'h8000_0001, 32'd0, "full cleared after first transfer");
    wr(3'd3, 32'h0);
    chk("R6", {31'd0, irq}, 32'd0, "status write clears interrupt");
    repeat (100) @(negedge clk);
    chk("R6", {31'd0, irq}, 32'd0, "no interrupt on going empty");
    chk("R5", reqn - base, 5, "request count");
    for (int i = 0; i < 5; i++)
      chk("R5", {8'd0, reqlog[base + i]}, {8'd0, exp_addr[i]}, $sformatf("request %0d address", i));
    rd(3'd3, d);
    chk("R2", d, 32'h0020_0000, "status idle after drain");
    rd(3'd1, d);
    chk("R3", d, 32'd0, "length idle after drain");

    // R4 disable, R1 alignment
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h12_3457);
    wr(3'd1, 32'h8);
    repeat (30) @(negedge clk);
    chk("R4", reqn - base, 5, "no request while disabled");
    rd(3'd1, d);
    chk("R4", d, 32'h8, "length kept while disabled");
    wr(3'd2, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4", reqn - base, 6, "request after enable");
    chk("R1", {8'd0, reqlog[base + 5]}, 32'h0012_3450, "aligned address");
    rd(3'd1, d);
    chk("R3", d, 32'd0, "length after last word");

    // audio path: R7, R8, R9
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(3'd5, 32'd1);
    wr(3'd4, 32'd131);
    wr(3'd0, 32'h400);
    wr(3'd1, 32'd16);
    wr(3'd0, 32'h800);
    wr(3'd1, 32'd8);
    cap_on = 1;
    wr(3'd2, 32'h1);
    p = dac_bclk;
    t = 0;
    while (dac_bclk == p && t < 50) begin @(negedge clk); t++; end
    p = dac_bclk; n = 0;
    while (dac_bclk == p && n < 50) begin @(negedge clk); n++; end
    chk("R7", n, 2, "bit clock half period");
    t = 0;
    while (!(dac_ws && !pws) && t < 400) begin @(negedge clk); t++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!(dac_ws && !pws) && n < 400);
    chk("R8", n, 132, "frame period");
    t = 0;
    while (fn < 12 && t < 3000) begin @(negedge clk); t++; end
    chk("R8", fn >= 12, 1, "frames captured");
    k = 0;
    while (k < fn - 8 && frames[k] == 32'd0) k++;
    for (int i = 0; i < 8; i++)
      chk(i < 6 ? "R8" : "R9", frames[k + i], exp_frm[i], $sformatf("frame %0d", i));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule